// File: doc/BRIEF.md
# Register-Pointer 8-bit CPU Core

This block is a small 8-bit processor core. It is built around a file of sixteen 16-bit registers. Two 4-bit selectors choose among them at run time: P picks the register that acts as the program counter and X picks the register that acts as the data pointer. Any register can take either role, and a program changes roles with one instruction. An 8-bit accumulator D holds results, and a one-bit flag DF holds carries, borrows and shifted-out bits.

Each instruction starts with a fetch cycle. In that cycle the opcode byte is read from R(P) and R(P) is stepped forward. An execute cycle follows. Long branches add a third cycle to read a second address byte. The memory port carries a 16-bit address, a read strobe, a write strobe and 8-bit data in each direction. Read data must be valid in the same cycle as the address, and a write takes effect at the clock edge in which the write strobe is high. The instruction byte splits into an opcode nibble in bits 7:4 and a field N in bits 3:0.

Top module: `ptrcore`

## Requirements
- R1: While reset is held, D, DF, P and X read 0. Every register in the file is cleared. The first fetch reads address 0x0000.
- R2: A fetch reads the byte at R(P) with the read strobe high and leaves R(P) one higher. Every instruction except a long branch takes two cycles, and the read and write strobes are never high together.
- R3: Opcode 0xEN copies N into X. Opcode 0xDN copies N into P, so the next fetch comes from R(N).
- R4: 0x0N loads D from M[R(N)]. 0x4N does the same and then adds 1 to R(N). 0x5N writes D to M[R(N)].
- R5: 0x1N adds 1 to R(N) and 0x2N subtracts 1 from R(N), both across the full 16 bits.
- R6: 0x8N copies the low byte of R(N) into D and 0x9N copies its high byte. 0xAN writes D into the low byte of R(N) and 0xBN writes D into its high byte. The other byte of R(N) is left alone.
- R7: 0xF0 loads D from M[R(X)]. 0x72 does the same and then adds 1 to R(X). 0x73 writes D to M[R(X)] and then subtracts 1 from R(X). 0x60 adds 1 to R(X).
- R8: 0xF1/0xF9 (OR), 0xF2/0xFA (AND) and 0xF3/0xFB (XOR) combine D with the operand into D and leave DF unchanged. 0xF0 and 0xF8 (load) also leave DF unchanged.
- R9: 0xF4/0xFC add the operand to D, and DF receives the carry out of bit 7.
- R10: 0xF5/0xFD put operand minus D into D. 0xF7/0xFF put D minus operand into D. In both cases DF is 1 exactly when no borrow occurs.
- R11: 0xF6 shifts D right by one with DF taking the old bit 0. 0xFE shifts D left by one with DF taking the old bit 7. Neither reads memory.
- R12: 0x3N is a short branch. N=0 always branches, N=2 branches on D==0, N=3 on DF=1, N=A on D!=0 and N=B on DF=0; any other N never branches. When taken, the low byte of R(P) becomes the byte that follows the opcode. When not taken, R(P) steps past that byte.
- R13: 0xCN is a long branch with the same conditions as R12 and takes three cycles. It reads the high target byte and then the low target byte. When taken, R(P) becomes the 16-bit target. When not taken, R(P) ends two past the opcode's successor.
- R14: For 0xF8 to 0xFF except 0xFE, the operand is the byte at R(P) during execute, and R(P) steps past it. For 0xF0 to 0xF7 the operand is M[R(X)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, write taken at the clock edge |
| mem_wdata | output | 8 | Write data (always D) |
| mem_rdata | input | 8 | Read data, valid in the same cycle as mem_addr |
| acc_o | output | 8 | Accumulator D |
| carry_o | output | 1 | Flag DF |
| pc_sel_o | output | 4 | P selector |
| ptr_sel_o | output | 4 | X selector |

## Verification
The properties assume that memory answers a read within the same cycle and that reset is applied before the first edge. They make no assumption about program content, so any byte stream is legal stimulus. The bench keeps within this by modelling memory as a combinational read array with writes taken at the edge. It resets the core before each program. Random operands and random branch conditions are placed only in operand slots of fixed program frames, so every run ends in a branch-to-self loop.

// File: rtl/ptrcore_pkg.sv
package ptrcore_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_LONG  = 2'd2
    } phase_e;

    localparam logic [3:0] OP_LDN = 4'h0;
    localparam logic [3:0] OP_INC = 4'h1;
    localparam logic [3:0] OP_DEC = 4'h2;
    localparam logic [3:0] OP_SBR = 4'h3;
    localparam logic [3:0] OP_LDA = 4'h4;
    localparam logic [3:0] OP_STR = 4'h5;
    localparam logic [3:0] OP_IRX = 4'h6;
    localparam logic [3:0] OP_XMV = 4'h7;
    localparam logic [3:0] OP_GLO = 4'h8;
    localparam logic [3:0] OP_GHI = 4'h9;
    localparam logic [3:0] OP_PLO = 4'hA;
    localparam logic [3:0] OP_PHI = 4'hB;
    localparam logic [3:0] OP_LBR = 4'hC;
    localparam logic [3:0] OP_SEP = 4'hD;
    localparam logic [3:0] OP_SEX = 4'hE;
    localparam logic [3:0] OP_ALU = 4'hF;

    // branch test shared by short and long forms
    function automatic logic cond_met(input logic [3:0] code, input logic zero, input logic flag);
        case (code)
            4'h0:    cond_met = 1'b1;
            4'h2:    cond_met = zero;
            4'h3:    cond_met = flag;
            4'hA:    cond_met = !zero;
            4'hB:    cond_met = !flag;
            default: cond_met = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ptrcore_regs.sv
module ptrcore_regs #(
    parameter int NREG = 16,
    parameter int AW   = 16,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [AW-1:0] wval,
    input  logic [SW-1:0] sel_p,
    input  logic [SW-1:0] sel_x,
    input  logic [SW-1:0] sel_n,
    output logic [AW-1:0] val_p,
    output logic [AW-1:0] val_x,
    output logic [AW-1:0] val_n
);
    logic [AW-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (we && wsel == SW'(g)) begin
                regs_q[g] <= wval;
            end
        end
    end

    assign val_p = regs_q[sel_p];
    assign val_x = regs_q[sel_x];
    assign val_n = regs_q[sel_n];
endmodule

// File: rtl/ptrcore_alu.sv
module ptrcore_alu #(
    parameter int DW = 8
) (
    input  logic [3:0]    fn,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    input  logic          df_in,
    output logic [DW-1:0] res,
    output logic          df_out
);
    localparam logic [DW:0] ONE = (DW+1)'(1);
    logic [DW:0] sum;

    always_comb begin
        sum    = '0;
        res    = opnd;
        df_out = df_in;
        case (fn[2:0])
            3'd1: res = acc | opnd;
            3'd2: res = acc & opnd;
            3'd3: res = acc ^ opnd;
            3'd4: begin
                sum    = {1'b0, acc} + {1'b0, opnd};
                res    = sum[DW-1:0];
                df_out = sum[DW];
            end
            3'd5: begin
                sum    = {1'b0, opnd} + {1'b0, ~acc} + ONE;
                res    = sum[DW-1:0];
                df_out = sum[DW];
            end
            3'd6: begin
                if (fn[3]) begin
                    res    = {acc[DW-2:0], 1'b0};
                    df_out = acc[DW-1];
                end else begin
                    res    = {1'b0, acc[DW-1:1]};
                    df_out = acc[0];
                end
            end
            3'd7: begin
                sum    = {1'b0, acc} + {1'b0, ~opnd} + ONE;
                res    = sum[DW-1:0];
                df_out = sum[DW];
            end
            default: res = opnd;
        endcase
    end
endmodule

// File: rtl/ptrcore.sv
module ptrcore #(
    parameter int DW   = 8,
    parameter int AW   = 16,
    parameter int NREG = 16,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] acc_o,
    output logic          carry_o,
    output logic [SW-1:0] pc_sel_o,
    output logic [SW-1:0] ptr_sel_o
);
    import ptrcore_pkg::*;

    localparam logic [AW-1:0] ONE = AW'(1);

    typedef struct packed {
        phase_e        ph;
        logic [3:0]    i;
        logic [3:0]    n;
        logic [DW-1:0] d;
        logic          df;
        logic [SW-1:0] p;
        logic [SW-1:0] x;
        logic [DW-1:0] hold;
    } core_t;

    core_t st_d, st_q;

    logic          rf_we;
    logic [SW-1:0] rf_sel;
    logic [AW-1:0] rf_val;
    logic [AW-1:0] rp_val, rx_val, rn_val;
    logic [DW-1:0] alu_res;
    logic          alu_df;
    logic          take;

    ptrcore_regs #(.NREG(NREG), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .wsel(rf_sel), .wval(rf_val),
        .sel_p(st_q.p), .sel_x(st_q.x), .sel_n(st_q.n),
        .val_p(rp_val), .val_x(rx_val), .val_n(rn_val)
    );

    ptrcore_alu #(.DW(DW)) u_alu (
        .fn(st_q.n), .acc(st_q.d), .opnd(mem_rdata), .df_in(st_q.df),
        .res(alu_res), .df_out(alu_df)
    );

    assign take = cond_met(st_q.n, st_q.d == '0, st_q.df);

    always_comb begin
        st_d      = st_q;
        mem_addr  = rp_val;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = st_q.d;
        rf_we     = 1'b0;
        rf_sel    = st_q.p;
        rf_val    = rp_val + ONE;
        case (st_q.ph)
            PH_FETCH: begin
                mem_rd  = 1'b1;
                st_d.i  = mem_rdata[DW-1:DW-4];
                st_d.n  = mem_rdata[3:0];
                rf_we   = 1'b1;
                st_d.ph = PH_EXEC;
            end
            PH_EXEC: begin
                st_d.ph = PH_FETCH;
                case (st_q.i)
                    OP_LDN, OP_LDA: begin
                        mem_addr = rn_val;
                        mem_rd   = 1'b1;
                        st_d.d   = mem_rdata;
                        rf_we    = (st_q.i == OP_LDA);
                        rf_sel   = st_q.n;
                        rf_val   = rn_val + ONE;
                    end
                    OP_INC, OP_DEC: begin
                        rf_we  = 1'b1;
                        rf_sel = st_q.n;
                        rf_val = (st_q.i == OP_INC) ? rn_val + ONE : rn_val - ONE;
                    end
                    OP_SBR: begin
                        mem_rd = 1'b1;
                        rf_we  = 1'b1;
                        if (take) rf_val = {rp_val[AW-1:DW], mem_rdata};
                    end
                    OP_STR: begin
                        mem_addr = rn_val;
                        mem_wr   = 1'b1;
                    end
                    OP_IRX: begin
                        rf_we  = (st_q.n == 4'h0);
                        rf_sel = st_q.x;
                        rf_val = rx_val + ONE;
                    end
                    OP_XMV: begin
                        mem_addr = rx_val;
                        rf_sel   = st_q.x;
                        if (st_q.n == 4'h2) begin
                            mem_rd = 1'b1;
                            st_d.d = mem_rdata;
                            rf_we  = 1'b1;
                            rf_val = rx_val + ONE;
                        end else if (st_q.n == 4'h3) begin
                            mem_wr = 1'b1;
                            rf_we  = 1'b1;
                            rf_val = rx_val - ONE;
                        end
                    end
                    OP_GLO: st_d.d = rn_val[DW-1:0];
                    OP_GHI: st_d.d = rn_val[AW-1:DW];
                    OP_PLO, OP_PHI: begin
                        rf_we  = 1'b1;
                        rf_sel = st_q.n;
                        rf_val = (st_q.i == OP_PLO) ? {rn_val[AW-1:DW], st_q.d}
                                                    : {st_q.d, rn_val[DW-1:0]};
                    end
                    OP_LBR: begin
                        mem_rd    = 1'b1;
                        rf_we     = 1'b1;
                        st_d.hold = mem_rdata;
                        st_d.ph   = PH_LONG;
                    end
                    OP_SEP: st_d.p = st_q.n;
                    OP_SEX: st_d.x = st_q.n;
                    default: begin
                        if (st_q.n[2:0] != 3'd6) begin
                            mem_rd = 1'b1;
                            if (st_q.n[3]) rf_we = 1'b1;
                            else           mem_addr = rx_val;
                        end
                        st_d.d  = alu_res;
                        st_d.df = alu_df;
                    end
                endcase
            end
            default: begin
                mem_rd  = 1'b1;
                rf_we   = 1'b1;
                st_d.ph = PH_FETCH;
                if (take) rf_val = {st_q.hold, mem_rdata};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_FETCH, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o     = st_q.d;
    assign carry_o   = st_q.df;
    assign pc_sel_o  = st_q.p;
    assign ptr_sel_o = st_q.x;
endmodule

// File: rtl/ptrcore_chk.sv
module ptrcore_chk #(
    parameter int DW = 8,
    parameter int AW = 16,
    parameter int SW = 4
) (
    input logic                clk,
    input logic                rst_n,
    input ptrcore_pkg::phase_e phase,
    input logic [3:0]          op_i,
    input logic [3:0]          op_n,
    input logic                mem_rd,
    input logic                mem_wr,
    input logic [AW-1:0]       mem_addr,
    input logic [DW-1:0]       mem_wdata,
    input logic [DW-1:0]       acc,
    input logic [SW-1:0]       pc_sel,
    input logic [SW-1:0]       ptr_sel,
    input logic [AW-1:0]       rp_val,
    input logic [AW-1:0]       rx_val
);
    import ptrcore_pkg::*;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R2

    AST_FETCH_FROM_PC: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FETCH |-> mem_rd && mem_addr == rp_val); // R2

    AST_EXEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FETCH |=> phase == PH_EXEC); // R2

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FETCH |=> rp_val == $past(rp_val) + AW'(1)); // R2

    AST_SEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && op_i == 4'hE) |=> ptr_sel == $past(op_n)); // R3

    AST_SEP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && op_i == 4'hD) |=> pc_sel == $past(op_n)); // R3

    AST_STXD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && op_i == 4'h7 && op_n == 4'h3)
        |-> mem_wr && mem_addr == rx_val && mem_wdata == acc); // R7

    AST_LONG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_LONG |-> $past(phase) == PH_EXEC && $past(op_i) == 4'hC); // R13
endmodule

bind ptrcore ptrcore_chk #(.DW(DW), .AW(AW), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .phase(st_q.ph), .op_i(st_q.i), .op_n(st_q.n),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .acc(acc_o), .pc_sel(pc_sel_o), .ptr_sel(ptr_sel_o),
    .rp_val(rp_val), .rx_val(rx_val)
);

// File: tb/ptrcore_test.sv
`timescale 1ns/1ps
module ptrcore_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  acc_o;
    logic        carry_o;
    logic [3:0]  pc_sel_o, ptr_sel_o;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] mem [0:4095];

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

    ptrcore uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_o(acc_o), .carry_o(carry_o),
        .pc_sel_o(pc_sel_o), .ptr_sel_o(ptr_sel_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wipe();
        rst_n = 1'b0;
        for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
    endtask

    task automatic put(input int a, input logic [7:0] v);
        mem[a] = v;
    endtask

    task automatic go(input int cycles);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (cycles) @(negedge clk);
        #1;
    endtask

    // reference result {df, d} of F-group op k
    function automatic logic [8:0] ref_alu(input logic [3:0] k, input logic [7:0] a,
                                           input logic [7:0] b, input logic df);
        case (k)
            4'h0, 4'h8: ref_alu = {df, b};
            4'h1, 4'h9: ref_alu = {df, a | b};
            4'h2, 4'hA: ref_alu = {df, a & b};
            4'h3, 4'hB: ref_alu = {df, a ^ b};
            4'h4, 4'hC: ref_alu = {1'b0, a} + {1'b0, b};
            4'h5, 4'hD: ref_alu = {(b >= a), 8'(b - a)};
            4'h7, 4'hF: ref_alu = {(a >= b), 8'(a - b)};
            4'h6:       ref_alu = {a[0], 1'b0, a[7:1]};
            default:    ref_alu = {a[7], a[6:0], 1'b0};
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] k);
        case (k)
            4'h4, 4'hC:                   req_of = "R9 add";
            4'h5, 4'h7, 4'hD, 4'hF:       req_of = "R10 subtract";
            4'h6, 4'hE:                   req_of = "R11 shift";
            4'h8, 4'h9, 4'hA, 4'hB:       req_of = "R14 immediate";
            default:                      req_of = "R8 logic/load";
        endcase
    endfunction

    function automatic logic ref_take(input logic [3:0] c, input logic [7:0] d, input logic df);
        case (c)
            4'h0: ref_take = 1'b1;
            4'h2: ref_take = (d == 8'h00);
            4'h3: ref_take = df;
            4'hA: ref_take = (d != 8'h00);
            4'hB: ref_take = !df;
            default: ref_take = 1'b0;
        endcase
    endfunction

    initial begin : watchdog
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [3:0] conds [6] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hA, 4'hB};
        void'($urandom(32'h5EED_0042));

        // reset state, R1
        wipe();
        @(negedge clk); #1;
        chk("R1 reset D", acc_o, 8'h00);
        chk("R1 reset DF", carry_o, 1'b0);
        chk("R1 reset P", pc_sel_o, 4'h0);
        chk("R1 reset X", ptr_sel_o, 4'h0);
        chk("R1 first fetch addr", mem_addr, 16'h0000);

        // cycle trace: LDI, long branch taken, R2 and R13
        wipe();
        put(0, 8'hF8); put(1, 8'h33); put(2, 8'hC0); put(3, 8'h00); put(4, 8'h08);
        put(8, 8'h30); put(9, 8'h08);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1; #1;
        begin
            int exp_a [7] = '{0, 1, 2, 3, 4, 8, 9};
            for (int c = 0; c < 7; c++) begin
                chk("R2 R13 address trace", mem_addr, exp_a[c]);
                chk("R2 read strobe", {mem_rd, mem_wr}, 2'b10);
                @(negedge clk); #1;
            end
        end

        // directed program
        wipe();
        begin
            logic [7:0] prog [0:80] = '{
                8'hF8, 8'h01, 8'hB4, 8'hF8, 8'h00, 8'hA4, 8'hF8, 8'h12,
                8'hB3, 8'hF8, 8'hFF, 8'hA3, 8'h13, 8'h93, 8'h54, 8'h83,
                8'h14, 8'h54, 8'h23, 8'h23, 8'h83, 8'h14, 8'h54, 8'h14,
                8'hE4, 8'hF8, 8'h5A, 8'h73, 8'h72, 8'h44, 8'h60, 8'h04,
                8'hF1, 8'hF7, 8'h32, 8'h26, 8'hF8, 8'hEE, 8'h33, 8'h29,
                8'hF8, 8'h3A, 8'h2C, 8'hF8, 8'h01, 8'h3B, 8'h30, 8'hC2,
                8'h00, 8'hE0, 8'hC0, 8'h00, 8'h40, 8'hF8, 8'hEE, 8'h00,
                8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                8'h84, 8'h54, 8'hF8, 8'h00, 8'hB5, 8'hF8, 8'h50, 8'hA5,
                8'hD5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                8'h30};
            for (int k = 0; k <= 80; k++) put(k, prog[k]);
            put(8'h51, 8'h50);
            put(16'h0105, 8'h77);
        end
        go(220);
        chk("R6 R5 GHI after INC carry", mem[16'h0100], 8'h13);
        chk("R6 GLO low byte", mem[16'h0101], 8'h00);
        chk("R5 DEC wrap", mem[16'h0102], 8'hFE);
        chk("R7 STXD write", mem[16'h0103], 8'h5A);
        chk("R4 R7 pointer steps", mem[16'h0105], 8'h05);
        chk("R3 SEP P", pc_sel_o, 4'h5);
        chk("R3 SEX X", ptr_sel_o, 4'h4);
        chk("R12 R13 branch path D", acc_o, 8'h50);
        chk("R10 SM equal DF", carry_o, 1'b1);
        chk("R3 fetch from new PC", mem_addr[15:1], 15'h0028);

        // random ALU trials, R8 R9 R10 R11 R14
        for (int t = 0; t < 80; t++) begin
            logic [7:0] a0, c0, a, b;
            logic [3:0] k;
            logic [8:0] pre, exp;
            a0 = 8'($urandom); c0 = 8'($urandom); a = 8'($urandom);
            b = (t % 5 == 0) ? a : 8'($urandom);
            k = 4'($urandom);
            pre = ref_alu(4'hC, a0, c0, 1'b0);
            wipe();
            put(0, 8'hF8); put(1, a0); put(2, 8'hFC); put(3, c0);
            put(4, 8'hF8); put(5, 8'h00); put(6, 8'hB1); put(7, 8'hF8); put(8, 8'h80);
            put(9, 8'hA1); put(10, 8'hE1); put(11, 8'hF8); put(12, a);
            put(13, {4'hF, k}); put(8'h80, b);
            if (k >= 4'h8 && k != 4'hE) begin
                put(14, b); put(15, 8'h30); put(16, 8'h0F);
            end else begin
                put(14, 8'h30); put(15, 8'h0E);
            end
            exp = ref_alu(k, a, b, pre[8]);
            go(60);
            chk(req_of(k), acc_o, exp[7:0]);
            chk(req_of(k), carry_o, exp[8]);
        end

        // random branch trials, R12 R13
        for (int t = 0; t < 60; t++) begin
            logic [7:0] a, b;
            logic [3:0] c;
            logic [8:0] r;
            logic       lng;
            a = 8'($urandom); b = (t % 3 == 0) ? a : 8'($urandom);
            c = conds[$urandom % 6];
            lng = 1'($urandom);
            r = ref_alu(4'hF, a, b, 1'b0);
            wipe();
            put(0, 8'hF8); put(1, a); put(2, 8'hFF); put(3, b);
            if (lng) begin
                put(4, {4'hC, c}); put(5, 8'h00); put(6, 8'h10);
                put(7, 8'hF8); put(8, 8'h11); put(9, 8'h30); put(10, 8'h09);
                put(16, 8'hF8); put(17, 8'h22); put(18, 8'h30); put(19, 8'h12);
            end else begin
                put(4, {4'h3, c}); put(5, 8'h0A);
                put(6, 8'hF8); put(7, 8'h11); put(8, 8'h30); put(9, 8'h08);
                put(10, 8'hF8); put(11, 8'h22); put(12, 8'h30); put(13, 8'h0C);
            end
            go(40);
            chk(lng ? "R13 long branch" : "R12 short branch", acc_o,
                ref_take(c, r[7:0], r[8]) ? 8'h22 : 8'h11);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule